// File: doc/BRIEF.md
# Status Flags and Conditional Flow Unit

This block holds the eight-bit processor status byte and decides, for each conditional branch or skip, whether the program counter moves and by how much. The execution stage feeds it flag results together with a per-bit write mask. Decode feeds it single-bit set, clear and T-transfer commands, and branch or skip requests with their operands. One test of one selected status bit, set or clear, covers every conditional branch. This includes the signed comparisons, which read the sign bit that the ALU stores.

The flag register is updated on the clock edge. The branch outcome, the next program counter, the instruction's cycle count and the T-load result are combinational from the current inputs and the stored flags. For a skip, the distance depends on whether the following instruction occupies one word or two. Decode provides that length as an input.

Top module: `flag_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status output is 8'h00.
- R2: At each clock edge, every status bit whose `alu_we_i` bit is 1 takes the matching `alu_flags_i` bit. Every other bit keeps its value, unless an explicit command targets it.
- R3: `flag_op_i` = 1 sets, and `flag_op_i` = 2 clears, the status bit chosen by `bit_idx_i` at the next edge. In the same cycle this command overrides the ALU update for that bit only.
- R4: `flag_op_i` = 3 copies `reg_in_i[bit_idx_i]` into T (status bit 6) at the next edge, and this overrides the ALU update of T. `bitld_o` always equals `reg_in_i` with bit `bit_idx_i` replaced by the current T.
- R5: The status bits are ordered from bit 7 to bit 0 as I, T, H, S, V, N, Z, C. With `br_req_i`=1, kind 0 branches when status bit `bit_idx_i` is 1, and kind 1 branches when that bit is 0. A taken branch lasts 2 cycles. A branch that is not taken gives `next_pc_o` = PC+1 and lasts 1 cycle.
- R6: A taken branch gives `next_pc_o` = PC + sign-extended 7-bit `br_off_i` + 1, wrapped modulo 2^PC_W. Examples: an offset of 7'h40 is -64, and 7'h7F is -1.
- R7: The skip kinds are 2 (skip when `opa_i` = `opb_i`), 3 (skip when `reg_in_i[bit_idx_i]` is 0) and 4 (skip when that bit is 1). A skip that is taken gives PC+2 and lasts 2 cycles when `next_long_i`=0, or PC+3 and lasts 3 cycles when `next_long_i`=1. A skip that is not taken gives PC+1 and lasts 1 cycle.
- R8: With `br_req_i`=0, or with a kind of 5 to 7, `taken_o` is 0, `next_pc_o` is PC+1 and `cycles_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_we_i | input | 8 | Per-bit write mask for ALU flags |
| alu_flags_i | input | 8 | Flag values from the ALU |
| flag_op_i | input | 2 | 0 none, 1 set bit, 2 clear bit, 3 store register bit into T |
| bit_idx_i | input | 3 | Bit index for commands, T load, branch and bit skips |
| reg_in_i | input | 8 | Register operand for T store, T load and bit skips |
| br_req_i | input | 1 | Branch or skip request |
| br_kind_i | input | 3 | 0 branch-if-set, 1 branch-if-clear, 2 skip-equal, 3 skip-bit-clear, 4 skip-bit-set |
| opa_i | input | 8 | First compare operand for skip-equal |
| opb_i | input | 8 | Second compare operand for skip-equal |
| br_off_i | input | 7 | Signed branch offset in words |
| pc_i | input | PC_W | Current program counter |
| next_long_i | input | 1 | Following instruction is two words long |
| sreg_o | output | 8 | Status byte |
| bitld_o | output | 8 | reg_in_i with the selected bit loaded from T |
| taken_o | output | 1 | Branch or skip is taken |
| next_pc_o | output | PC_W | Next program counter |
| cycles_o | output | 2 | Cycle count of the instruction |

## Verification
`taken_o`, `next_pc_o`, `cycles_o` and `bitld_o` are due in the same cycle as their inputs. The bench therefore samples them one nanosecond after it drives the inputs, before the next clock edge. A flag update or T store appears on `sreg_o` only after that edge. The bench samples `sreg_o` at the following falling edge and compares it with a reference model that it advances at the same edge. Branches and skips that run right after a flag change therefore see the new value one cycle later, exactly as the model does.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;
    localparam int FLAG_W  = 8;
    localparam int IDX_W   = $clog2(FLAG_W);
    localparam int T_POS   = 6;

    typedef enum logic [1:0] {
        FOP_NONE   = 2'd0,
        FOP_SET    = 2'd1,
        FOP_CLR    = 2'd2,
        FOP_TSTORE = 2'd3
    } flag_op_e;

    typedef enum logic [2:0] {
        BK_FSET = 3'd0,
        BK_FCLR = 3'd1,
        BK_SKEQ = 3'd2,
        BK_SKBC = 3'd3,
        BK_SKBS = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;
endpackage

// File: rtl/flagbr_status.sv
module flagbr_status
    import flagbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLAG_W-1:0]    alu_we,
    input  logic [FLAG_W-1:0]    alu_flags,
    input  logic [1:0]           flag_op,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic [DATA_W-1:0]    reg_in,
    output logic [FLAG_W-1:0]    flags_o,
    output logic [DATA_W-1:0]    bitld_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~alu_we) | (alu_flags & alu_we);
        case (flag_op)
            FOP_SET:    st_d.flags[bit_idx] = 1'b1;
            FOP_CLR:    st_d.flags[bit_idx] = 1'b0;
            FOP_TSTORE: st_d.flags[T_POS]   = reg_in[bit_idx];
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bitld_o          = reg_in;
        bitld_o[bit_idx] = st_q.flags[T_POS];
    end

    assign flags_o = st_q.flags;

    a_r3_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op == FOP_SET) |=> st_q.flags[$past(bit_idx)]);
    a_r3_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op == FOP_CLR) |=> !st_q.flags[$past(bit_idx)]);
    a_r2_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op == FOP_NONE && alu_we == '0) |=> $stable(st_q.flags));
    a_r4_t_store: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_op == FOP_TSTORE) |=> st_q.flags[T_POS] == $past(reg_in[bit_idx]));
endmodule

// File: rtl/flagbr_cond.sv
module flagbr_cond
    import flagbr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [FLAG_W-1:0]  flags,
    input  logic               req,
    input  logic [2:0]         kind,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0]  reg_in,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic               hit,
    output logic               is_skip
);
    logic sel_flag, sel_reg;

    assign sel_flag = flags[bit_idx];
    assign sel_reg  = reg_in[bit_idx];

    always_comb begin
        hit     = 1'b0;
        is_skip = 1'b0;
        case (kind)
            BK_FSET: hit = sel_flag;
            BK_FCLR: hit = !sel_flag;
            BK_SKEQ: begin hit = (opa == opb); is_skip = 1'b1; end
            BK_SKBC: begin hit = !sel_reg;     is_skip = 1'b1; end
            BK_SKBS: begin hit = sel_reg;      is_skip = 1'b1; end
            default: ;
        endcase
        if (!req) hit = 1'b0;
    end
endmodule

// File: rtl/flagbr_pcgen.sv
module flagbr_pcgen #(
    parameter int PC_W  = 10,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic             hit,
    input  logic             is_skip,
    input  logic             next_long,
    output logic [PC_W-1:0]  next_pc,
    output logic [1:0]       cycles
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};

    always_comb begin
        step   = PC_W'(1);
        cycles = 2'd1;
        if (hit) begin
            if (is_skip) begin
                step   = next_long ? PC_W'(3) : PC_W'(2);
                cycles = next_long ? 2'd3 : 2'd2;
            end else begin
                step   = off_ext + PC_W'(1);
                cycles = 2'd2;
            end
        end
        next_pc = pc + step;
    end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import flagbr_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        alu_we_i,
    input  logic [7:0]        alu_flags_i,
    input  logic [1:0]        flag_op_i,
    input  logic [2:0]        bit_idx_i,
    input  logic [7:0]        reg_in_i,
    input  logic              br_req_i,
    input  logic [2:0]        br_kind_i,
    input  logic [7:0]        opa_i,
    input  logic [7:0]        opb_i,
    input  logic [6:0]        br_off_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              next_long_i,
    output logic [7:0]        sreg_o,
    output logic [7:0]        bitld_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic [1:0]        cycles_o
);
    logic hit, is_skip;

    flagbr_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we_i), .alu_flags(alu_flags_i),
        .flag_op(flag_op_i), .bit_idx(bit_idx_i), .reg_in(reg_in_i),
        .flags_o(sreg_o), .bitld_o(bitld_o)
    );

    flagbr_cond #(.DATA_W(DATA_W)) u_cond (
        .flags(sreg_o), .req(br_req_i), .kind(br_kind_i), .bit_idx(bit_idx_i),
        .reg_in(reg_in_i), .opa(opa_i), .opb(opb_i), .hit(hit), .is_skip(is_skip)
    );

    flagbr_pcgen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pcgen (
        .pc(pc_i), .off(br_off_i), .hit(hit), .is_skip(is_skip),
        .next_long(next_long_i), .next_pc(next_pc_o), .cycles(cycles_o)
    );

    assign taken_o = hit;

    a_r8_idle_flow: assert property (@(posedge clk) disable iff (!rst_n)
        !br_req_i |-> (!taken_o && cycles_o == 2'd1));
    a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (next_pc_o == pc_i + PC_W'(1)));
    a_r5_taken_two: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && br_kind_i < 3'd2) |-> cycles_o == 2'd2);
    a_r7_skip_distance: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && br_kind_i >= 3'd2) |-> (next_pc_o - pc_i) == PC_W'(cycles_o));
endmodule

// File: tb/test_flag_branch_unit.sv
`timescale 1ns/1ps
module test_flag_branch_unit;
    localparam int PC_W = 10;
    localparam int PC_M = 1 << PC_W;

    logic clk = 0, rst_n = 0;
    logic [7:0] alu_we, alu_flags, reg_in, opa, opb, sreg, bitld;
    logic [1:0] fop, cyc;
    logic [2:0] idx, kind;
    logic       req, lng, taken;
    logic [6:0] off;
    logic [PC_W-1:0] pc, npc;

    int checks = 0, fails = 0;
    int m_sreg = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flag_branch_unit #(.PC_W(PC_W)) i_flag_branch_unit (
        .clk(clk), .rst_n(rst_n), .alu_we_i(alu_we), .alu_flags_i(alu_flags),
        .flag_op_i(fop), .bit_idx_i(idx), .reg_in_i(reg_in), .br_req_i(req),
        .br_kind_i(kind), .opa_i(opa), .opb_i(opb), .br_off_i(off), .pc_i(pc),
        .next_long_i(lng), .sreg_o(sreg), .bitld_o(bitld), .taken_o(taken),
        .next_pc_o(npc), .cycles_o(cyc)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(int we, int fl, int op, int bi, int rin, int rq, int kd,
                        int a, int b, int o, int p, int lg);
        int e_hit, e_pc, e_cyc, sk, ns, skip, t;
        string btag;
        alu_we = 8'(we); alu_flags = 8'(fl); fop = 2'(op); idx = 3'(bi);
        reg_in = 8'(rin); req = rq[0]; kind = 3'(kd); opa = 8'(a); opb = 8'(b);
        off = 7'(o); pc = PC_W'(p); lng = lg[0];
        #1;
        // behavioural reference
        e_hit = 0; skip = (kd >= 2 && kd <= 4);
        if (rq != 0) begin
            case (kd)
                0: e_hit = (m_sreg >> bi) & 1;
                1: e_hit = ((m_sreg >> bi) & 1) ^ 1;
                2: e_hit = ((a & 255) == (b & 255)) ? 1 : 0;
                3: e_hit = ((rin >> bi) & 1) ^ 1;
                4: e_hit = (rin >> bi) & 1;
                default: e_hit = 0;
            endcase
        end
        sk = (o & 127) >= 64 ? (o & 127) - 128 : (o & 127);
        if (!e_hit) begin e_pc = p + 1; e_cyc = 1; end
        else if (skip) begin e_pc = p + (lg ? 3 : 2); e_cyc = lg ? 3 : 2; end
        else begin e_pc = p + sk + 1; e_cyc = 2; end
        e_pc = ((e_pc % PC_M) + PC_M) % PC_M;
        btag = (rq == 0 || kd > 4) ? "R8" : (skip ? "R7" : "R5");
        chk(btag, "taken", int'(taken), e_hit);
        chk(btag, "cycles", int'(cyc), e_cyc);
        chk((e_hit && !skip) ? "R6" : btag, "next_pc", int'(npc), e_pc);
        t = (m_sreg >> 6) & 1;
        chk("R4", "bitld", int'(bitld), ((rin & 255) & ~(1 << bi)) | (t << bi));
        ns = (m_sreg & ~we) | (fl & we);
        if (op == 1) ns = ns | (1 << bi);
        else if (op == 2) ns = ns & ~(1 << bi);
        else if (op == 3) ns = (ns & ~64) | (((rin >> bi) & 1) << 6);
        m_sreg = ns & 255;
        @(negedge clk);
        chk(op == 3 ? "R4" : (op != 0 ? "R3" : "R2"), "sreg", int'(sreg), m_sreg);
    endtask

    initial begin
        alu_we = 0; alu_flags = 0; fop = 0; idx = 0; reg_in = 0; req = 0; kind = 0;
        opa = 0; opb = 0; off = 0; pc = 0; lng = 0;
        repeat (3) @(negedge clk);
        chk("R1", "sreg in reset", int'(sreg), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "sreg after reset", int'(sreg), 0);
        // R2 masked ALU update
        step(8'h0F, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
        step(8'hF0, 8'h50, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
        step(8'h00, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
        // R3 explicit set/clear wins over ALU on its bit
        step(8'hFF, 8'h00, 1, 3, 0, 0, 0, 0, 0, 0, 5, 0);
        step(8'hFF, 8'hFF, 2, 1, 0, 0, 0, 0, 0, 0, 5, 0);
        // R4 T store over ALU, then load
        step(8'h40, 8'h40, 3, 2, 8'hFB, 0, 0, 0, 0, 0, 5, 0);
        step(8'h00, 8'h00, 3, 5, 8'h20, 0, 0, 0, 0, 0, 5, 0);
        step(8'h00, 8'h00, 0, 7, 8'h00, 0, 0, 0, 0, 0, 5, 0);
        // R5 signed less-than via bit 4, branch-if-clear
        step(8'hFF, 8'h10, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
        step(0, 0, 0, 4, 0, 1, 0, 0, 0, 8'h05, 100, 0);
        step(0, 0, 0, 4, 0, 1, 1, 0, 0, 8'h05, 100, 0);
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 8'h05, 100, 0);
        // R6 offset extremes and wrap
        step(0, 0, 0, 4, 0, 1, 0, 0, 0, 8'h40, 10, 0);
        step(0, 0, 0, 4, 0, 1, 0, 0, 0, 8'h3F, 1000, 0);
        step(0, 0, 0, 4, 0, 1, 0, 0, 0, 8'h7F, 0, 0);
        // R7 skips, short and long, taken and not
        step(0, 0, 0, 0, 0, 1, 2, 8'h33, 8'h33, 0, 200, 0);
        step(0, 0, 0, 0, 0, 1, 2, 8'h33, 8'h33, 0, 1022, 1);
        step(0, 0, 0, 0, 0, 1, 2, 8'h33, 8'h34, 0, 200, 1);
        step(0, 0, 0, 6, 8'h00, 1, 3, 0, 0, 0, 300, 1);
        step(0, 0, 0, 6, 8'h40, 1, 4, 0, 0, 0, 300, 0);
        step(0, 0, 0, 6, 8'h00, 1, 4, 0, 0, 0, 300, 1);
        // R8 idle and unused kinds
        step(0, 0, 0, 4, 8'hFF, 0, 0, 1, 1, 8'h10, 1023, 1);
        step(0, 0, 0, 4, 8'hFF, 1, 6, 1, 1, 8'h10, 50, 1);
        for (int n = 0; n < 3000; n++)
            step($urandom, $urandom, $urandom % 4, $urandom % 8, $urandom,
                 $urandom % 2, $urandom % 8, $urandom % 4, $urandom % 4,
                 $urandom, $urandom, $urandom % 2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule